// File: doc/BRIEF.md
# Last Branch Record Ring

This block keeps the most recent control transfers seen by a processor core in a ring of `DEPTH` entries. Each entry holds the address a transfer left from and the address it went to. The core offers one event per cycle through a strobe with a kind code and the two addresses. The block stores taken branches, interrupts and exceptions. It never stores debug exceptions, and it stores nothing while recording is switched off.

A top-of-stack index always names the entry written most recently. On each stored event the index first steps forward by one, wrapping from `DEPTH-1` to 0, and the new pair is then written at that position, so the oldest entry is overwritten. Debug software reads any entry through a combinational read port, by entry number.

The recording controls come from a 16-bit control word, loaded by a write strobe. Bit 0 enables recording. Bit 11 makes a monitor-interrupt pulse freeze the ring. A frozen ring stores nothing, but it can still be read. The freeze lasts until the control word is written again.

Top module: `lbr_ring`

## Requirements
- R1: After reset the top-of-stack index is 0 and every entry reads zero for both source and destination.
- R2: With control bit 0 set and the ring not frozen, an event of kind 0 (taken branch), 1 (interrupt) or 2 (exception) moves the top-of-stack index to (index+1) mod DEPTH at the next clock edge, and that entry then holds the event's source and destination.
- R3: An event of kind 3 (debug exception) is never stored: the index and all entries stay unchanged.
- R4: While control bit 0 is clear, no event is stored.
- R5: After more than DEPTH stored events, the index has wrapped and only the latest DEPTH events are held, each at its position modulo DEPTH.
- R6: While control bit 11 is set, a monitor-interrupt pulse freezes the ring from the next cycle. A frozen ring stores no event, and its contents stay readable.
- R7: The freeze lasts until a control-word write, which clears it. A write in the same cycle as a monitor-interrupt pulse leaves the ring unfrozen.
- R8: While control bit 11 is clear, a monitor-interrupt pulse has no effect on recording.
- R9: The read port returns the source and destination of entry `rd_idx` combinationally, in the same cycle, for any index.
- R10: A control-word write takes effect from the next cycle. An event in the same cycle as the write is judged by the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Loads the control word and clears a freeze |
| ctl_word | input | 16 | Control word: bit 0 enables recording, bit 11 enables freeze on monitor interrupt |
| mon_irq | input | 1 | Monitor-interrupt request pulse |
| evt_valid | input | 1 | An event is offered this cycle |
| evt_kind | input | 2 | 0 branch, 1 interrupt, 2 exception, 3 debug exception |
| evt_src | input | AW | Source address of the transfer |
| evt_dst | input | AW | Destination address of the transfer |
| rd_idx | input | IW | Entry number to read |
| rd_src | output | AW | Source address held in entry `rd_idx` |
| rd_dst | output | AW | Destination address held in entry `rd_idx` |
| tos | output | IW | Index of the most recently written entry |

## Verification
The properties assume that `rd_idx` stays below DEPTH and that `evt_kind` is always a defined two-bit code. They also assume that the index only moves because an event was offered in the cycle before. The stimulus drives every input half a cycle away from the rising edge and never drives an out-of-range read index. Monitor-interrupt and control-write pulses last exactly one cycle, so each freeze and each release can be placed on a known edge.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [1:0] {
    XFER_BRANCH = 2'd0,
    XFER_IRQ    = 2'd1,
    XFER_EXC    = 2'd2,
    XFER_DBG    = 2'd3
  } xfer_kind_e;

  localparam int CTL_W       = 16;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_FRZ_BIT = 11;
endpackage

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             mon_irq,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  output logic             rec_go,
  output logic             frz_q
);
  logic en_q, en_d;
  logic fctl_q, fctl_d;
  logic frz_d;

  // next state: a control write wins over a monitor interrupt
  always_comb begin
    en_d   = en_q;
    fctl_d = fctl_q;
    frz_d  = frz_q;
    if (ctl_wr) begin
      en_d   = ctl_word[CTL_EN_BIT];
      fctl_d = ctl_word[CTL_FRZ_BIT];
      frz_d  = 1'b0;
    end else if (fctl_q && mon_irq) begin
      frz_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fctl_q <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      fctl_q <= fctl_d;
      frz_q  <= frz_d;
    end
  end

  assign rec_go = evt_valid && en_q && !frz_q && (evt_kind != XFER_DBG);
endmodule

// File: rtl/lbr_ptr.sv
module lbr_ptr #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [IW-1:0] tos_q,
  output logic [IW-1:0] tos_nxt
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  logic [IW-1:0] tos_d;

  assign tos_nxt = (tos_q == LAST) ? '0 : tos_q + 1'b1;

  always_comb begin
    tos_d = tos_q;
    if (step) tos_d = tos_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tos_q <= '0;
    else        tos_q <= tos_d;
  end
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_dst,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst
);
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ce;
    assign ce = we && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g] <= '0;
        dst_q[g] <= '0;
      end else if (ce) begin
        src_q[g] <= wr_src;
        dst_q[g] <= wr_dst;
      end
    end
  end

  always_comb begin
    rd_src = '0;
    rd_dst = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (rd_idx == IW'(k)) begin
        rd_src = src_q[k];
        rd_dst = dst_q[k];
      end
    end
  end
endmodule

// File: rtl/lbr_ring.sv
module lbr_ring
  import lbr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             mon_irq,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic [AW-1:0]    evt_src,
  input  logic [AW-1:0]    evt_dst,
  input  logic [IW-1:0]    rd_idx,
  output logic [AW-1:0]    rd_src,
  output logic [AW-1:0]    rd_dst,
  output logic [IW-1:0]    tos
);
  logic          rec_go;
  logic          frozen;
  logic [IW-1:0] tos_nxt;

  lbr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .mon_irq(mon_irq), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .rec_go(rec_go), .frz_q(frozen)
  );

  lbr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(rec_go), .tos_q(tos), .tos_nxt(tos_nxt)
  );

  lbr_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(rec_go), .wr_idx(tos_nxt),
    .wr_src(evt_src), .wr_dst(evt_dst), .rd_idx(rd_idx),
    .rd_src(rd_src), .rd_dst(rd_dst)
  );
endmodule

// File: rtl/lbr_ring_chk.sv
module lbr_ring_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic          evt_valid,
  input logic [1:0]    evt_kind,
  input logic [AW-1:0] evt_src,
  input logic [AW-1:0] evt_dst,
  input logic [IW-1:0] rd_idx,
  input logic [AW-1:0] rd_src,
  input logic [AW-1:0] rd_dst,
  input logic [IW-1:0] tos,
  input logic          frozen
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  p_tos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tos <= LAST);

  p_tos_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tos) |-> (tos == (($past(tos) == LAST) ? '0 : $past(tos) + 1'b1)));

  p_dbg_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'd3) |=> $stable(tos));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(tos));

  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(tos));

  p_wr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !frozen);

  p_new_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tos) && rd_idx == tos) |->
      (rd_src == $past(evt_src) && rd_dst == $past(evt_dst)));
endmodule

bind lbr_ring lbr_ring_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .evt_valid(evt_valid),
  .evt_kind(evt_kind), .evt_src(evt_src), .evt_dst(evt_dst),
  .rd_idx(rd_idx), .rd_src(rd_src), .rd_dst(rd_dst), .tos(tos),
  .frozen(frozen)
);

// File: tb/lbr_ring_tb_top.sv
module lbr_ring_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int IW    = $clog2(DEPTH);
  localparam int NVEC  = 14;
  localparam logic [15:0] W_EN  = 16'h0001;
  localparam logic [15:0] W_FRZ = 16'h0801;
  // event kinds walked by the main loop; code 3 is a debug exception
  localparam logic [1:0] VEC [NVEC] = '{2'd0, 2'd1, 2'd3, 2'd2, 2'd0, 2'd0,
                                        2'd3, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0,
                                        2'd2, 2'd0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [15:0]   ctl_word = '0;
  logic          mon_irq = 1'b0;
  logic          evt_valid = 1'b0;
  logic [1:0]    evt_kind = '0;
  logic [AW-1:0] evt_src = '0;
  logic [AW-1:0] evt_dst = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [AW-1:0] rd_src, rd_dst;
  logic [IW-1:0] tos;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bench reference
  logic [AW-1:0] m_src [DEPTH];
  logic [AW-1:0] m_dst [DEPTH];
  int  m_tos = 0;
  bit  m_en = 0, m_fctl = 0, m_frz = 0;

  always #10 clk = ~clk;

  lbr_ring #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .mon_irq(mon_irq), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_src(evt_src), .evt_dst(evt_dst), .rd_idx(rd_idx),
    .rd_src(rd_src), .rd_dst(rd_dst), .tos(tos)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tos == IW'(m_tos), tag, AW'(tos), AW'(m_tos));
    for (int k = 0; k < DEPTH; k++) begin
      rd_idx = IW'(k);
      #1;
      chk(rd_src == m_src[k], tag, rd_src, m_src[k]);
      chk(rd_dst == m_dst[k], tag, rd_dst, m_dst[k]);
    end
  endtask

  // one cycle of stimulus, starting and ending at a falling edge
  task automatic cycle(input bit v, input logic [1:0] kind, input logic [AW-1:0] s,
                       input logic [AW-1:0] d, input bit wr, input logic [15:0] w,
                       input bit irq);
    evt_valid = v; evt_kind = kind; evt_src = s; evt_dst = d;
    ctl_wr = wr; ctl_word = w; mon_irq = irq;
    // reference: event judged by current settings
    if (v && m_en && !m_frz && kind != 2'd3) begin
      m_tos = (m_tos + 1) % DEPTH;
      m_src[m_tos] = s;
      m_dst[m_tos] = d;
    end
    if (wr) begin
      m_en = w[0]; m_fctl = w[11]; m_frz = 0;
    end else if (m_fctl && irq) begin
      m_frz = 1;
    end
    @(negedge clk);
    evt_valid = 0; ctl_wr = 0; mon_irq = 0;
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      m_src[k] = '0; m_dst[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R4: recording off after reset
    cycle(1, 2'd0, 32'hAAAA0000, 32'hBBBB0000, 0, '0, 0);
    check_all("R4 disabled");

    // R10: write enables; event in same cycle is still judged as disabled
    cycle(1, 2'd0, 32'hC0C00001, 32'hD0D00001, 1, W_EN, 0);
    check_all("R10 same-cycle write");

    // table walk: R2, R3, R5
    for (int i = 0; i < NVEC; i++) begin
      cycle(1, VEC[i], 32'h1000_0000 + AW'(i * 16), 32'h2000_0000 + AW'(i * 32),
            0, '0, 0);
      if (VEC[i] == 2'd3) check_all("R3 debug skipped");
      else                check_all("R2 stored");
    end
    check_all("R5 wrapped");

    // R9: read port follows rd_idx without a clock
    rd_idx = IW'(m_tos);
    #1;
    chk(rd_src == m_src[m_tos], "R9 comb read", rd_src, m_src[m_tos]);

    // R8: freeze control clear, monitor interrupt does nothing
    cycle(0, 2'd0, '0, '0, 0, '0, 1);
    cycle(1, 2'd1, 32'h3333_0001, 32'h4444_0001, 0, '0, 0);
    check_all("R8 no freeze");

    // R6: freeze armed, pulse, then events ignored but readable
    cycle(0, 2'd0, '0, '0, 1, W_FRZ, 0);
    cycle(1, 2'd0, 32'h5555_0001, 32'h6666_0001, 0, '0, 1);
    check_all("R6 event with pulse stored");
    cycle(1, 2'd2, 32'h5555_0002, 32'h6666_0002, 0, '0, 0);
    cycle(1, 2'd0, 32'h5555_0003, 32'h6666_0003, 0, '0, 0);
    check_all("R6 frozen");

    // R7: write clears the freeze
    cycle(0, 2'd0, '0, '0, 1, W_FRZ, 0);
    cycle(1, 2'd0, 32'h7777_0001, 32'h8888_0001, 0, '0, 0);
    check_all("R7 released");

    // R7: write in same cycle as pulse leaves the ring unfrozen
    cycle(0, 2'd0, '0, '0, 1, W_FRZ, 1);
    cycle(1, 2'd1, 32'h7777_0002, 32'h8888_0002, 0, '0, 0);
    check_all("R7 write beats pulse");

    // R10: disabling write still records same-cycle event, not the next
    cycle(1, 2'd0, 32'h9999_0001, 32'hAAAA_0001, 1, '0, 0);
    cycle(1, 2'd0, 32'h9999_0002, 32'hAAAA_0002, 0, '0, 0);
    check_all("R10 disable timing");

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    #3;
    for (int k = 0; k < DEPTH; k++) begin
      m_src[k] = '0; m_dst[k] = '0;
    end
    m_tos = 0; m_en = 0; m_fctl = 0; m_frz = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 re-reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule